// File: doc/BRIEF.md
# Three-Stage Nonblocking Circuit Switch

This block joins twelve word-wide input lanes to twelve word-wide output lanes through three ranks of small crossbars. There are three ingress nodes of four ports each, seven centre nodes, and three egress nodes of four ports each. Every centre node has exactly one link to each ingress node and one link to each egress node. A controller takes one request at a time. A request either sets up a path from an input port to an output port or tears down the path that leaves an input port. For a setup, the controller finds a centre node whose link from the source's ingress node and whose link to the destination's egress node are both idle. It then writes the select of each of the three ranks.

The centre rank has twice the group size minus one nodes. Each ingress node can have at most three other paths leaving it, and each egress node at most three other paths entering it, so together they can occupy at most six centre nodes. A seventh node is always left free for a legal setup. As a result, a setup never has to move a path that already exists. Data words pass through combinationally once a path is set up. Any output that has no path drives zero, and its valid flag is low.

Top module: `clos3_switch`

## Requirements
- R1: After reset, every `dout_valid` bit is 0, `dout` is all zeros, and both `done` and `err` are 0.
- R2: A request is sampled on a rising edge while `req_valid` is 1. Its outcome appears after the following rising edge. At that point exactly one of `done` or `err` is 1, and it stays 1 for one cycle only.
- R3: An output with a path has its `dout_valid` bit set to 1. In the same cycle, its word carries the word of its source input. Port p sits in the lane `[p*W +: W]` and belongs to group p/4.
- R4: An output without a path drives an all-zero word, and its `dout_valid` bit is 0.
- R5: A setup (`req_release`=0) is rejected with `err` if its input already has a path or its output is already driven. When rejected, no output changes.
- R6: A request that names a port index of 12 to 15 is rejected with `err`. When rejected, no output changes.
- R7: A release (`req_release`=1) of an input that has a path gives `done`, and the output that input fed becomes invalid and zero. A release of an input without a path gives `err`.
- R8: A successful setup leaves every path that existed before it unchanged, in both valid flag and data.
- R9: A setup whose input and output ports are both free always succeeds, whatever paths already exist. This holds up to and including a full set of twelve paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_release | input | 1 | 0 = set up a path, 1 = tear down the path from `req_in` |
| req_in | input | 4 | Source input port index |
| req_out | input | 4 | Destination output port index (used only for setup) |
| din | input | 96 | Twelve input words of 8 bits each |
| dout | output | 96 | Twelve output words of 8 bits each |
| dout_valid | output | 12 | Per-output flag showing that a path exists |
| done | output | 1 | Request completed |
| err | output | 1 | Request rejected |

## Verification
The hardest case to reach is a setup where the source group and the destination group each already carry three other paths, and those paths use six different centre nodes. In that case, only one centre node remains free. The stimulus fills the switch to a full permutation of twelve paths, then tears paths down and sets them up again. A long random run with heavy setup bias follows. Under that bias the switch is usually close to full, so many setups meet groups that are nearly saturated. Every setup that the reference model calls legal is expected to succeed.

// File: rtl/clos3_switch.sv
module clos3_switch #(
  parameter int PORTS = 12,
  parameter int N     = 4,
  parameter int W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_release,
  input  logic [$clog2(PORTS)-1:0]      req_in,
  input  logic [$clog2(PORTS)-1:0]      req_out,
  input  logic [PORTS*W-1:0]            din,
  output logic [PORTS*W-1:0]            dout,
  output logic [PORTS-1:0]              dout_valid,
  output logic                          done,
  output logic                          err
);
  localparam int NODES = PORTS / N;
  localparam int MID   = 2 * N - 1;
  localparam int PW    = $clog2(PORTS);
  localparam int MW    = $clog2(MID);
  localparam int NW    = $clog2(NODES);
  localparam int LW    = $clog2(N);

  logic          p_v, p_rel;
  logic [PW-1:0] p_in, p_out;

  logic [MID-1:0]   isel_v [NODES];
  logic [LW-1:0]    isel   [NODES][MID];
  logic [NODES-1:0] msel_v [MID];
  logic [NW-1:0]    msel   [MID][NODES];
  logic [PORTS-1:0] osel_v;
  logic [MW-1:0]    osel   [PORTS];
  logic [PORTS-1:0] in_conn;
  logic [PW-1:0]    in_dst [PORTS];

  logic [NW-1:0] src_n, dst_n, rel_dn;
  logic [LW-1:0] src_l;
  logic [PW-1:0] rel_dst;
  logic [MW-1:0] rel_m, pick;
  logic          found, ok;

  assign src_n   = NW'(p_in / PW'(N));
  assign dst_n   = NW'(p_out / PW'(N));
  assign src_l   = LW'(p_in % PW'(N));
  assign rel_dst = in_dst[p_in];
  assign rel_dn  = NW'(rel_dst / PW'(N));
  assign rel_m   = osel[rel_dst];

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int m = MID - 1; m >= 0; m--) begin
      if (!isel_v[src_n][m] && !msel_v[m][dst_n]) begin
        pick  = MW'(m);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (p_rel)
      ok = (32'(p_in) < PORTS) && in_conn[p_in];
    else
      ok = (32'(p_in) < PORTS) && (32'(p_out) < PORTS) &&
           !in_conn[p_in] && !osel_v[p_out] && found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_v     <= 1'b0;
      p_rel   <= 1'b0;
      p_in    <= '0;
      p_out   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      osel_v  <= '0;
      in_conn <= '0;
      for (int i = 0; i < NODES; i++) isel_v[i] <= '0;
      for (int m = 0; m < MID; m++)   msel_v[m] <= '0;
    end else begin
      p_v   <= req_valid;
      p_rel <= req_release;
      p_in  <= req_in;
      p_out <= req_out;
      done  <= p_v && ok;
      err   <= p_v && !ok;
      if (p_v && ok) begin
        if (!p_rel) begin
          isel_v[src_n][pick] <= 1'b1;
          msel_v[pick][dst_n] <= 1'b1;
          osel_v[p_out]       <= 1'b1;
          in_conn[p_in]       <= 1'b1;
        end else begin
          isel_v[src_n][rel_m]  <= 1'b0;
          msel_v[rel_m][rel_dn] <= 1'b0;
          osel_v[rel_dst]       <= 1'b0;
          in_conn[p_in]         <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (p_v && ok && !p_rel) begin
      isel[src_n][pick] <= src_l;
      msel[pick][dst_n] <= src_n;
      osel[p_out]       <= pick;
      in_dst[p_in]      <= p_out;
    end
  end

  logic [W-1:0] link [NODES][MID];
  logic [W-1:0] mout [MID][NODES];

  always_comb begin
    for (int i = 0; i < NODES; i++)
      for (int m = 0; m < MID; m++)
        link[i][m] = din[(i * N + int'(isel[i][m])) * W +: W];
    for (int m = 0; m < MID; m++)
      for (int k = 0; k < NODES; k++)
        mout[m][k] = msel_v[m][k] ? link[msel[m][k]][m] : '0;
    for (int o = 0; o < PORTS; o++)
      dout[o * W +: W] = osel_v[o] ? mout[osel[o]][o / N] : '0;
  end

  assign dout_valid = osel_v;
endmodule

module clos3_switch_chk #(
  parameter int PORTS = 12,
  parameter int W     = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_release,
  input logic [PORTS*W-1:0]       dout,
  input logic [PORTS-1:0]         dout_valid,
  input logic                     done,
  input logic                     err
);
  // R2
  outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 (done ^ err));

  // R2
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> $past(req_valid, 2));

  // R8
  keep_paths_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(req_release, 2)) |->
      (((~dout_valid) & $past(dout_valid)) == '0) &&
      ($countones(dout_valid) == $countones($past(dout_valid)) + 1));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_release, 2)) |->
      ($countones(dout_valid) + 1 == $countones($past(dout_valid))));

  // R5
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (dout_valid == $past(dout_valid)));

  for (genvar o = 0; o < PORTS; o++) begin : g_idle
    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_valid[o] |-> (dout[o * W +: W] == '0));
  end
endmodule

bind clos3_switch clos3_switch_chk #(.PORTS(PORTS), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_release(req_release),
  .dout(dout), .dout_valid(dout_valid), .done(done), .err(err)
);

// File: tb/tb_clos3_switch.sv
module tb_clos3_switch;
  localparam int CLK_PERIOD = 10;
  localparam int PORTS = 12;
  localparam int W = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_release = 1'b0;
  logic [3:0]           req_in = '0;
  logic [3:0]           req_out = '0;
  logic [PORTS*W-1:0]   din = '0;
  logic [PORTS*W-1:0]   dout;
  logic [PORTS-1:0]     dout_valid;
  logic                 done, err;

  int tests = 0;
  int fails = 0;
  int exp_dst [PORTS];
  int exp_src [PORTS];

  clos3_switch #(.PORTS(PORTS), .N(4), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_release(req_release),
    .req_in(req_in), .req_out(req_out), .din(din), .dout(dout),
    .dout_valid(dout_valid), .done(done), .err(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit good, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [PORTS*W-1:0] exp_dout();
    logic [PORTS*W-1:0] v = '0;
    for (int o = 0; o < PORTS; o++)
      if (exp_src[o] >= 0) v[o*W +: W] = din[exp_src[o]*W +: W];
    return v;
  endfunction

  function automatic logic [PORTS-1:0] exp_valid();
    logic [PORTS-1:0] v = '0;
    for (int o = 0; o < PORTS; o++) v[o] = (exp_src[o] >= 0);
    return v;
  endfunction

  task automatic check_outputs(input string req);
    for (int i = 0; i < PORTS; i++) din[i*W +: W] = W'($urandom);
    #1;
    check(dout_valid == exp_valid(), {req, " valid"}, 128'(dout_valid), 128'(exp_valid()));
    check(dout == exp_dout(), {req, " data"}, 128'(dout), 128'(exp_dout()));
  endtask

  task automatic do_req(input bit rel, input int src, input int dst, input string req);
    bit legal;
    @(negedge clk);
    req_valid = 1'b1; req_release = rel; req_in = 4'(src); req_out = 4'(dst);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (rel) legal = (src < PORTS) && (exp_dst[src] >= 0);
    else     legal = (src < PORTS) && (dst < PORTS) && (exp_dst[src] < 0) && (exp_src[dst] < 0);
    // R2 outcome flags after two edges
    check({done, err} == {legal, !legal}, {req, " R2 outcome"}, 128'({done, err}),
          128'({legal, !legal}));
    if (legal) begin
      if (rel) begin
        exp_src[exp_dst[src]] = -1;
        exp_dst[src] = -1;
      end else begin
        exp_dst[src] = dst;
        exp_src[dst] = src;
      end
    end
    check_outputs(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < PORTS; i++) begin exp_dst[i] = -1; exp_src[i] = -1; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dout_valid == '0 && dout == '0 && !done && !err, "R1 reset",
          128'(dout), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 R4 idle after reset");

    do_req(1'b0, 0, 5, "R3 setup 0->5");
    // R2 single-cycle pulse
    @(negedge clk);
    check(!done && !err, "R2 pulse width", 128'({done, err}), 128'(0));
    do_req(1'b0, 13, 2, "R6 bad input index");
    do_req(1'b0, 2, 15, "R6 bad output index");
    do_req(1'b0, 0, 7, "R5 busy input");
    do_req(1'b0, 3, 5, "R5 busy output");
    do_req(1'b1, 4, 0, "R7 release unconnected");
    do_req(1'b1, 14, 0, "R6 release bad index");
    do_req(1'b1, 0, 0, "R7 release connected");

    for (int i = 0; i < PORTS; i++)
      do_req(1'b0, i, (i * 5 + 7) % PORTS, "R9 R8 full permutation");
    for (int i = 0; i < PORTS; i += 3)
      do_req(1'b1, i, 0, "R7 partial teardown");
    for (int i = 0; i < PORTS; i += 3)
      do_req(1'b0, i, (i * 7 + 1) % PORTS, "R9 refill");

    for (int n = 0; n < 1500; n++) begin
      int s, d;
      bit rel;
      s = ($urandom % 10 == 0) ? 12 + int'($urandom % 4) : int'($urandom % PORTS);
      d = ($urandom % 10 == 0) ? 12 + int'($urandom % 4) : int'($urandom % PORTS);
      rel = ($urandom % 10) < 3;
      do_req(rel, s, d, "R5 R6 R7 R8 R9 random");
    end

    for (int i = 0; i < PORTS; i++)
      if (exp_dst[i] >= 0) do_req(1'b1, i, 0, "R7 final teardown");
    check_outputs("R4 all idle");
    finish_run();
  end
endmodule